// File: doc/BRIEF.md
# Service Request Status Byte

This block keeps the status byte of an instrument-side bus interface and decides when the instrument asks the controller for service. Each cycle it registers three summary flags from status structures elsewhere: operation, event-status and questionable. It also holds a sticky message-available flag that the output queue sets. From these it builds an eight-bit status byte. An eight-bit enable mask selects which of those bits may contribute to a master summary.

Bit 6 of the byte has two meanings. A plain read (the read strobe) captures the byte with the live master summary in bit 6 and changes nothing. A serial poll (the poll strobe) captures the byte with a latched request-for-service flag in bit 6 instead. The poll then clears that flag. The flag is set by a rising edge of the master summary, and the service-request line to the controller follows it. A clear-status strobe empties the message-available flag.

Top module: `srq_status_byte`

## Requirements
- R1: Status byte layout: bit 7 operation summary, bit 6 master summary (read) or request-for-service (poll), bit 5 event-status summary, bit 4 message available, bit 3 questionable summary. Bits 2..0 are always 0 in both captured bytes. Summary inputs appear in the byte one clock after they are sampled.
- R2: The master summary is the OR of status byte bits 7, 5, 4 and 3, each ANDed with the same-numbered enable mask bit. Mask bits 6 and 2..0 have no effect.
- R3: When mask_we_i is high at a clock edge, the mask takes mask_wdata_i (any value 0 to 255). The new mask governs the master summary from the next cycle.
- R4: While the mask is 0, srq_o never rises.
- R5: rd_stb_i captures into rd_byte_o the status byte with the master summary in bit 6. It clears no flag. rd_byte_o holds its value between reads.
- R6: The request-for-service flag sets at the edge following a rising edge of the master summary. It stays set until a serial poll. srq_o equals this flag.
- R7: poll_stb_i captures into poll_byte_o the status byte with the flag value before the poll in bit 6, then clears the flag. The master summary is not changed by the poll.
- R8: The message-available flag sets while mav_i is high and stays set until clr_i or reset. clr_i wins over mav_i in the same cycle.
- R9: If a poll and a new rising edge of the master summary occur in the same cycle, the flag stays set.
- R10: After reset the mask, the flag, the summary bits and both captured bytes are 0, and srq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| oper_sum_i | input | 1 | Operation summary flag |
| esb_sum_i | input | 1 | Event-status summary flag |
| ques_sum_i | input | 1 | Questionable summary flag |
| mav_i | input | 1 | Output queue holds a message |
| mask_we_i | input | 1 | Enable mask write strobe |
| mask_wdata_i | input | 8 | Enable mask write value |
| clr_i | input | 1 | Clear-status strobe |
| rd_stb_i | input | 1 | Status byte read strobe |
| poll_stb_i | input | 1 | Serial poll strobe |
| rd_byte_o | output | 8 | Byte captured by the last read |
| poll_byte_o | output | 8 | Byte captured by the last serial poll |
| srq_o | output | 1 | Service request to the controller |

## Verification
A serial poll can fall in the same cycle as a fresh rising edge of the master summary. In that cycle one event clears the flag and the other sets it. The bench forces this case in a directed sequence: it enables only the operation bit, raises and drops that bit, then raises it again and issues the poll exactly on the edge where the summary rises. The result counts as correct if the poll byte carries the old flag and srq_o stays high afterwards. Random traffic with frequent polls and mask changes hits the same overlap many more times, and a reference model built from the requirements judges every cycle.

// File: rtl/srq_pkg.sv
package srq_pkg;
  localparam int unsigned SB_W     = 8;
  localparam int unsigned B_OPER   = 7;
  localparam int unsigned B_SUMM   = 6;
  localparam int unsigned B_ESB    = 5;
  localparam int unsigned B_MAV    = 4;
  localparam int unsigned B_QUES   = 3;
  localparam int unsigned ZERO_W   = 3;
  localparam logic [SB_W-1:0] SUM_MASK =
    (SB_W'(1) << B_OPER) | (SB_W'(1) << B_ESB) |
    (SB_W'(1) << B_MAV)  | (SB_W'(1) << B_QUES);

  function automatic logic [SB_W-1:0] put_bit6(input logic [SB_W-1:0] b,
                                               input logic v);
    logic [SB_W-1:0] r;
    r = b & SUM_MASK;
    r[B_SUMM] = v;
    return r;
  endfunction
endpackage

// File: rtl/srq_sum_reg.sv
module srq_sum_reg
  import srq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            oper_i,
  input  logic            esb_i,
  input  logic            ques_i,
  input  logic            mav_i,
  input  logic            clr_i,
  output logic [SB_W-1:0] bits_o
);
  logic oper_q, esb_q, ques_q, mav_q;
  logic mav_d;

  always_comb begin
    if (clr_i)      mav_d = 1'b0;
    else if (mav_i) mav_d = 1'b1;
    else            mav_d = mav_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oper_q <= 1'b0;
      esb_q  <= 1'b0;
      ques_q <= 1'b0;
      mav_q  <= 1'b0;
    end else begin
      oper_q <= oper_i;
      esb_q  <= esb_i;
      ques_q <= ques_i;
      mav_q  <= mav_d;
    end
  end

  always_comb begin
    bits_o         = '0;
    bits_o[B_OPER] = oper_q;
    bits_o[B_ESB]  = esb_q;
    bits_o[B_MAV]  = mav_q;
    bits_o[B_QUES] = ques_q;
  end
endmodule

// File: rtl/srq_mss_gen.sv
module srq_mss_gen
  import srq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [SB_W-1:0] wdata_i,
  input  logic [SB_W-1:0] bits_i,
  output logic [SB_W-1:0] mask_o,
  output logic            mss_o
);
  logic [SB_W-1:0] mask_q, mask_d;
  logic [SB_W-1:0] hit;

  always_comb begin
    mask_d = mask_q;
    if (we_i) mask_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  // only the summary positions may contribute; bit 6 never feeds itself
  generate
    for (genvar i = 0; i < SB_W; i++) begin : g_hit
      if (SUM_MASK[i]) begin : g_on
        assign hit[i] = bits_i[i] & mask_q[i];
      end else begin : g_off
        assign hit[i] = 1'b0;
      end
    end
  endgenerate

  assign mss_o  = |hit;
  assign mask_o = mask_q;
endmodule

// File: rtl/srq_rqs_ctrl.sv
module srq_rqs_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mss_i,
  input  logic poll_i,
  output logic rqs_o,
  output logic mss_prev_o
);
  logic rqs_q, rqs_d;
  logic prev_q;
  logic rise;

  assign rise = mss_i & ~prev_q;

  always_comb begin
    rqs_d = rqs_q;
    if (rise)        rqs_d = 1'b1;
    else if (poll_i) rqs_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rqs_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      rqs_q  <= rqs_d;
      prev_q <= mss_i;
    end
  end

  assign rqs_o      = rqs_q;
  assign mss_prev_o = prev_q;
endmodule

// File: rtl/srq_status_byte.sv
module srq_status_byte
  import srq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            oper_sum_i,
  input  logic            esb_sum_i,
  input  logic            ques_sum_i,
  input  logic            mav_i,
  input  logic            mask_we_i,
  input  logic [SB_W-1:0] mask_wdata_i,
  input  logic            clr_i,
  input  logic            rd_stb_i,
  input  logic            poll_stb_i,
  output logic [SB_W-1:0] rd_byte_o,
  output logic [SB_W-1:0] poll_byte_o,
  output logic            srq_o
);
  logic            rst_s1_q, rst_s2_q, rst_n;
  logic [SB_W-1:0] sb_bits, mask_q;
  logic            mss, mss_prev, rqs;
  logic [SB_W-1:0] rd_q, rd_d, poll_q, poll_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_n = rst_s2_q;

  srq_sum_reg u_sum (
    .clk_i (clk_i), .rst_ni(rst_n),
    .oper_i(oper_sum_i), .esb_i(esb_sum_i), .ques_i(ques_sum_i),
    .mav_i (mav_i), .clr_i(clr_i), .bits_o(sb_bits)
  );

  srq_mss_gen u_mss (
    .clk_i (clk_i), .rst_ni(rst_n),
    .we_i  (mask_we_i), .wdata_i(mask_wdata_i),
    .bits_i(sb_bits), .mask_o(mask_q), .mss_o(mss)
  );

  srq_rqs_ctrl u_rqs (
    .clk_i (clk_i), .rst_ni(rst_n),
    .mss_i (mss), .poll_i(poll_stb_i),
    .rqs_o (rqs), .mss_prev_o(mss_prev)
  );

  always_comb begin
    rd_d   = rd_q;
    poll_d = poll_q;
    if (rd_stb_i)   rd_d   = put_bit6(sb_bits, mss);
    if (poll_stb_i) poll_d = put_bit6(sb_bits, rqs);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      poll_q <= '0;
    end else begin
      rd_q   <= rd_d;
      poll_q <= poll_d;
    end
  end

  assign rd_byte_o   = rd_q;
  assign poll_byte_o = poll_q;
  assign srq_o       = rqs;
endmodule

// File: rtl/srq_status_byte_chk.sv
module srq_status_byte_chk
  import srq_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            clr_i,
  input logic            rd_stb_i,
  input logic            poll_stb_i,
  input logic [SB_W-1:0] rd_byte_o,
  input logic [SB_W-1:0] poll_byte_o,
  input logic            srq_o,
  input logic [SB_W-1:0] sb_bits,
  input logic [SB_W-1:0] mask_q,
  input logic            mss,
  input logic            mss_prev
);
  AST_LOW_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_byte_o[ZERO_W-1:0] == '0) && (poll_byte_o[ZERO_W-1:0] == '0)); // R1
  AST_SRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srq_o && !poll_stb_i) |=> srq_o); // R6
  AST_ZERO_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0 && !srq_o) |=> !srq_o); // R4
  AST_READ_KEEPS_SRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && !poll_stb_i && srq_o) |=> srq_o); // R5
  AST_CLEAR_MAV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !sb_bits[B_MAV]); // R8
  AST_POLL_RISE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_stb_i && mss && !mss_prev) |=> srq_o); // R9
  AST_POLL_BIT6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_stb_i |=> (poll_byte_o[B_SUMM] == $past(srq_o))); // R7
endmodule

bind srq_status_byte srq_status_byte_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .rd_stb_i(rd_stb_i),
  .poll_stb_i(poll_stb_i), .rd_byte_o(rd_byte_o), .poll_byte_o(poll_byte_o),
  .srq_o(srq_o), .sb_bits(sb_bits), .mask_q(mask_q), .mss(mss),
  .mss_prev(mss_prev)
);

// File: tb/test_srq_status_byte.sv
module test_srq_status_byte;
  logic clk = 1'b0, rst_n = 1'b0;
  logic oper = 0, esb = 0, ques = 0, mav = 0, mwe = 0, clr = 0, rd = 0, poll = 0;
  logic [7:0] mwd = 8'h00;
  logic [7:0] rd_byte, poll_byte;
  logic srq;
  int checks = 0, errors = 0;

  // reference state, from the requirements
  logic m_oper = 0, m_esb = 0, m_ques = 0, m_mav = 0, m_prev = 0, m_rqs = 0;
  logic [7:0] m_mask = 0, m_rd = 0, m_poll = 0;

  always #5 clk = ~clk;

  srq_status_byte i_srq_status_byte (
    .clk_i(clk), .rst_ni(rst_n), .oper_sum_i(oper), .esb_sum_i(esb),
    .ques_sum_i(ques), .mav_i(mav), .mask_we_i(mwe), .mask_wdata_i(mwd),
    .clr_i(clr), .rd_stb_i(rd), .poll_stb_i(poll), .rd_byte_o(rd_byte),
    .poll_byte_o(poll_byte), .srq_o(srq)
  );

  function automatic logic f_mss();
    return (m_oper & m_mask[7]) | (m_esb & m_mask[5]) |
           (m_mav & m_mask[4]) | (m_ques & m_mask[3]);
  endfunction

  function automatic logic [7:0] f_byte(input logic b6);
    return {m_oper, b6, m_esb, m_mav, m_ques, 3'b000};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(input string req);
    logic cm;
    @(posedge clk);
    cm = f_mss();
    if (rd)   m_rd   = f_byte(cm);
    if (poll) m_poll = f_byte(m_rqs);
    if (cm && !m_prev) m_rqs = 1'b1;
    else if (poll)     m_rqs = 1'b0;
    m_prev = cm;
    m_oper = oper; m_esb = esb; m_ques = ques;
    m_mav  = clr ? 1'b0 : (mav ? 1'b1 : m_mav);
    if (mwe) m_mask = mwd;
    #2;
    chk({req, " rd_byte"}, rd_byte, m_rd);
    chk({req, " poll_byte"}, poll_byte, m_poll);
    chk({req, " srq"}, {7'd0, srq}, {7'd0, m_rqs});
    @(negedge clk);
    {oper, esb, ques, mav, mwe, clr, rd, poll} = '0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step("R10 reset");
    chk("R10 reset srq", {7'd0, srq}, 8'h00);

    // R4: mask zero, busy inputs, no request
    for (int i = 0; i < 40; i++) begin
      {oper, esb, ques, mav} = 4'($urandom);
      rd = 1'($urandom); clr = ($urandom % 4) == 0;
      step("R4 zero mask");
      chk("R4 srq low", {7'd0, srq}, 8'h00);
    end
    clr = 1; step("R8 clear");

    // R2: only bit 6 and low bits enabled -> nothing
    mwe = 1; mwd = 8'h47; step("R3 write");
    oper = 1; esb = 1; ques = 1; mav = 1; step("R2 drive");
    oper = 1; esb = 1; ques = 1; rd = 1; step("R2 ignored mask bits");
    chk("R2 bit6 clear", {7'd0, rd_byte[6]}, 8'h00);
    chk("R1 layout", rd_byte, 8'hB8);
    clr = 1; mav = 1; step("R8 clr wins");

    // R9 directed collision
    mwe = 1; mwd = 8'h80; step("R3 mask oper");
    oper = 1; step("R6 rise");
    step("R6 set");
    chk("R6 srq set", {7'd0, srq}, 8'h01);
    rd = 1; step("R5 read keeps");
    chk("R5 srq kept", {7'd0, srq}, 8'h01);
    oper = 1; step("hold");
    step("drop");
    oper = 1; step("R9 rise again");
    poll = 1; oper = 1; step("R9 poll on rise");
    chk("R9 srq stays", {7'd0, srq}, 8'h01);
    chk("R7 poll bit6 old", {7'd0, poll_byte[6]}, 8'h01);
    oper = 1; poll = 1; step("R7 poll clears");
    chk("R7 srq cleared", {7'd0, srq}, 8'h00);
    oper = 1; rd = 1; step("R7 mss unchanged");
    chk("R7 read mss", {7'd0, rd_byte[6]}, 8'h01);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      {oper, esb, ques} = 3'($urandom);
      mav  = ($urandom % 5) == 0;
      clr  = ($urandom % 7) == 0;
      rd   = 1'($urandom);
      poll = ($urandom % 3) == 0;
      mwe  = ($urandom % 10) == 0;
      mwd  = 8'($urandom);
      step("R6 R7 R9 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule